// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two 8-bit operands one bit per clock. Two 8-bit registers hold the operands, a single one-bit full adder combines their low bits with a stored carry, and each sum bit enters the accumulator register at its top end. The operand register is rotated rather than shifted, so once eight shift clocks have passed the accumulator holds the sum and the operand register holds the addend it started with. A flip-flop keeps the carry between bit positions and, after the last shift, presents the carry out of the whole sum.

Each register is steered by its own 2-bit mode code, so the two may be driven independently or tied together. A typical addition loads both registers in one clock, shifts both for eight clocks, then returns both to hold. The mode codes decode into four named actions: `MODE_HOLD` (0), `MODE_SPARE` (1, treated as hold), `MODE_SHIFT` (2) and `MODE_LOAD` (3). Every transition is a move between these actions: any action to `MODE_LOAD` captures the bus, any action to `MODE_SHIFT` advances one bit, and `MODE_HOLD` or `MODE_SPARE` freezes the register.

Top module: `serial_add8`

## Requirements
- R1: While rst_n is low, both registers and the carry flip-flop read zero, including when rst_n falls in the middle of a shift sequence.
- R2: Mode code 3 on a register captures its input bus on the rising clock edge; mode code 3 on the accumulator also clears the carry flip-flop to 0.
- R3: Mode codes 0 and 1 keep a register unchanged; the carry flip-flop is unchanged whenever the accumulator mode is 0 or 1.
- R4: Mode code 2 on the accumulator shifts it right by one bit, with the full-adder sum of accumulator bit 0, operand bit 0 and the stored carry entering bit 7; the carry flip-flop takes that adder's carry out on the same edge.
- R5: Mode code 2 on the operand register rotates it right by one bit, with bit 0 moving into bit 7, so eight such clocks restore its starting value.
- R6: After loading operands x and y, then eight clocks with both modes at 2, the accumulator reads (x + y) mod 256, the carry output reads bit 8 of x + y, and the operand register reads y.
- R7: The two mode inputs act independently in the same clock: one register may load while the other shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_i | input | 8 | Parallel input for the accumulator |
| opb_i | input | 8 | Parallel input for the operand register |
| mode_a_i | input | 2 | Mode code for the accumulator and carry |
| mode_b_i | input | 2 | Mode code for the operand register |
| reg_a_o | output | 8 | Accumulator contents (sum after eight shifts) |
| reg_b_o | output | 8 | Operand register contents |
| carry_o | output | 1 | Stored carry; final carry out after eight shifts |

## Verification
A parallel load of the accumulator and a rotation of the operand register can fall in the same clock, and the load must also clear the carry that the shift path would otherwise update. The bench provokes this by first leaving the carry set and the operand register non-zero, then applying load code to the accumulator and shift code to the operand register in one cycle. It judges the result at the ports: the accumulator equals the new bus value, the carry reads zero, and the operand register shows exactly one rotation.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_SPARE = 2'd1,
        MODE_SHIFT = 2'd2,
        MODE_LOAD  = 2'd3
    } mode_e;

endpackage

// File: rtl/sadd_sreg.sv
module sadd_sreg
    import sadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mode_e        mode,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] q
);

    logic [W-1:0] q_nxt;

    always_comb begin
        unique case (mode)
            MODE_LOAD:  q_nxt = par_in;
            MODE_SHIFT: q_nxt = {ser_in, q[W-1:1]};
            MODE_HOLD:  q_nxt = q;
            MODE_SPARE: q_nxt = q;
            default:    q_nxt = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_nxt;
        end
    end

endmodule

// File: rtl/sadd_fa.sv
module sadd_fa (
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic sum,
    output logic cout
);

    always_comb begin
        sum  = a ^ b ^ cin;
        cout = (a & b) | (cin & (a ^ b));
    end

endmodule

// File: rtl/sadd_carry.sv
module sadd_carry
    import sadd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  cout,
    output logic  cq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq <= 1'b0;
        end else begin
            unique case (mode)
                MODE_LOAD:  cq <= 1'b0;
                MODE_SHIFT: cq <= cout;
                MODE_HOLD:  cq <= cq;
                MODE_SPARE: cq <= cq;
                default:    cq <= cq;
            endcase
        end
    end

endmodule

// File: rtl/serial_add8.sv
module serial_add8
    import sadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [1:0]   mode_a_i,
    input  logic [1:0]   mode_b_i,
    output logic [W-1:0] reg_a_o,
    output logic [W-1:0] reg_b_o,
    output logic         carry_o
);

    mode_e        mode_a;
    mode_e        mode_b;
    logic [W-1:0] acc_q;
    logic [W-1:0] opd_q;
    logic         carry_q;
    logic         sum_bit;
    logic         cout_bit;

    assign mode_a = mode_e'(mode_a_i);
    assign mode_b = mode_e'(mode_b_i);

    sadd_fa u_fa (
        .a    (acc_q[0]),
        .b    (opd_q[0]),
        .cin  (carry_q),
        .sum  (sum_bit),
        .cout (cout_bit)
    );

    sadd_sreg #(.W(W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_a),
        .par_in (opa_i),
        .ser_in (sum_bit),
        .q      (acc_q)
    );

    sadd_sreg #(.W(W)) u_opd (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_b),
        .par_in (opb_i),
        .ser_in (opd_q[0]),
        .q      (opd_q)
    );

    sadd_carry u_cy (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_a),
        .cout  (cout_bit),
        .cq    (carry_q)
    );

    always_comb begin
        reg_a_o = acc_q;
        reg_b_o = opd_q;
        carry_o = carry_q;
    end

endmodule

// File: rtl/serial_add8_chk.sv
module serial_add8_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic [1:0]   mode_a_i,
    input logic [1:0]   mode_b_i,
    input logic [W-1:0] reg_a_o,
    input logic [W-1:0] reg_b_o,
    input logic         carry_o
);

    AST_LOAD_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a_i == 2'd3) |=> (reg_a_o == $past(opa_i)));                  // R2
    AST_LOAD_OPD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b_i == 2'd3) |=> (reg_b_o == $past(opb_i)));                  // R2
    AST_LOAD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a_i == 2'd3) |=> !carry_o);                                   // R2
    AST_HOLD_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a_i[1] == 1'b0) |=> $stable(reg_a_o));                        // R3
    AST_HOLD_OPD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b_i[1] == 1'b0) |=> $stable(reg_b_o));                        // R3
    AST_HOLD_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a_i[1] == 1'b0) |=> $stable(carry_o));                        // R3
    AST_SHIFT_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a_i == 2'd2) |=> (reg_a_o[W-2:0] == $past(reg_a_o[W-1:1])));  // R4
    AST_SHIFT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a_i == 2'd2) |=>
        ({carry_o, reg_a_o[W-1]} ==
         2'($past(reg_a_o[0]) + $past(reg_b_o[0]) + $past(carry_o))));     // R4
    AST_ROT_OPD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b_i == 2'd2) |=>
        (reg_b_o == {$past(reg_b_o[0]), $past(reg_b_o[W-1:1])}));          // R5

endmodule

bind serial_add8 serial_add8_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .mode_a_i (mode_a_i),
    .mode_b_i (mode_b_i),
    .reg_a_o  (reg_a_o),
    .reg_b_o  (reg_b_o),
    .carry_o  (carry_o)
);

// File: tb/sim_serial_add8.sv
`timescale 1ns/1ps
module sim_serial_add8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opa = 8'h00;
    logic [7:0] opb = 8'h00;
    logic [1:0] ma = 2'd0;
    logic [1:0] mb = 2'd0;
    logic [7:0] ra;
    logic [7:0] rb;
    logic       cy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    serial_add8 u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .opa_i    (opa),
        .opb_i    (opb),
        .mode_a_i (ma),
        .mode_b_i (mb),
        .reg_a_o  (ra),
        .reg_b_o  (rb),
        .carry_o  (cy)
    );

    localparam int NV = 7;
    localparam logic [15:0] VEC [NV] = '{
        16'h3F_3B, 16'h00_00, 16'hFF_01, 16'hFF_FF,
        16'h80_80, 16'hAA_55, 16'h7E_C3
    };

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // set inputs at a falling edge; the next rising edge acts on them;
    // returns at the following falling edge where outputs are stable
    task automatic cyc(input logic [1:0] a_m, input logic [1:0] b_m);
        ma = a_m;
        mb = b_m;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset holds everything at zero even with load code applied
        opa = 8'hA5; opb = 8'h5A; ma = 2'd3; mb = 2'd3;
        repeat (3) @(negedge clk);
        chk("R1 acc in reset", {1'b0, ra}, 9'h000);
        chk("R1 opd in reset", {1'b0, rb}, 9'h000);
        chk("R1 carry in reset", {8'h00, cy}, 9'h000);
        ma = 2'd0; mb = 2'd0;
        rst_n = 1'b1;
        @(negedge clk);

        // R6: table of operand pairs, full 8-shift additions
        for (int i = 0; i < NV; i++) begin
            logic [8:0] s;
            opa = VEC[i][15:8];
            opb = VEC[i][7:0];
            s = 9'(VEC[i][15:8]) + 9'(VEC[i][7:0]);
            cyc(2'd3, 2'd3);
            chk("R2 load acc", {1'b0, ra}, {1'b0, VEC[i][15:8]});
            for (int k = 0; k < 8; k++) cyc(2'd2, 2'd2);
            cyc(2'd0, 2'd0);
            chk("R6 sum", {1'b0, ra}, {1'b0, s[7:0]});
            chk("R6 carry out", {8'h00, cy}, {8'h00, s[8]});
            chk("R6 addend kept", {1'b0, rb}, {1'b0, VEC[i][7:0]});
        end

        // R3: after 7E+C3 the carry is 1; hold codes 0 and 1 change nothing
        opa = 8'h11; opb = 8'h22;
        cyc(2'd1, 2'd1);
        cyc(2'd0, 2'd1);
        cyc(2'd1, 2'd0);
        chk("R3 acc held", {1'b0, ra}, 9'h041);
        chk("R3 opd held", {1'b0, rb}, 9'h0C3);
        chk("R3 carry held", {8'h00, cy}, 9'h001);

        // R2: load of the accumulator clears the carry
        opa = 8'h03; opb = 8'h01;
        cyc(2'd3, 2'd3);
        chk("R2 carry cleared", {8'h00, cy}, 9'h000);
        chk("R2 load opd", {1'b0, rb}, 9'h001);

        // R4/R5: one shift of 03 with 01: sum bit 0, carry 1
        cyc(2'd2, 2'd2);
        chk("R4 acc one shift", {1'b0, ra}, 9'h001);
        chk("R4 carry captured", {8'h00, cy}, 9'h001);
        chk("R5 opd one rotate", {1'b0, rb}, 9'h080);

        // R7: accumulator loads while operand rotates in the same clock
        opa = 8'hF0;
        cyc(2'd3, 2'd2);
        chk("R7 acc loaded", {1'b0, ra}, 9'h0F0);
        chk("R7 carry cleared", {8'h00, cy}, 9'h000);
        chk("R7 opd rotated", {1'b0, rb}, 9'h040);

        // R5: eight rotations restore the operand, accumulator held
        for (int k = 0; k < 8; k++) cyc(2'd0, 2'd2);
        chk("R5 opd restored", {1'b0, rb}, 9'h040);
        chk("R3 acc held during rotate", {1'b0, ra}, 9'h0F0);

        // R1: reset in the middle of a shift sequence
        opa = 8'hFF; opb = 8'hFF;
        cyc(2'd3, 2'd3);
        cyc(2'd2, 2'd2);
        cyc(2'd2, 2'd2);
        #1 rst_n = 1'b0;
        #0.5;
        chk("R1 acc mid-shift reset", {1'b0, ra}, 9'h000);
        chk("R1 opd mid-shift reset", {1'b0, rb}, 9'h000);
        chk("R1 carry mid-shift reset", {8'h00, cy}, 9'h000);
        @(negedge clk);
        ma = 2'd0; mb = 2'd0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule